// File: doc/BRIEF.md
# Multi-View Pixel Aperture

This block holds a small pixel store in which every pixel keeps 26 bits: three 8-bit colour planes (red, green, blue) and a 2-bit per-pixel display-mode field. A host reaches that one store through three address windows, and each window shows a different view of the same pixels. The full view exposes all 26 bits as one 32-bit word per pixel. The colour view exposes the 24 colour bits only, so host writes through it never disturb the mode bits. The byte view packs the red plane of four neighbouring pixels into one 32-bit word and leaves every other plane alone. A fourth window code is reserved.

The host port is a valid/ready request channel with a one-cycle read response. The pixel store is split into four banks, one per byte lane, so a byte-view word reaches four pixels in one cycle while full and colour accesses touch one bank only. Reads are registered. A read issued in the cycle after a write to the same pixel returns the new data.

Top module: `pix_aperture`

## Requirements
- R1: `req_ready` is high in every cycle from the first clock edge after reset is released. A request is accepted when `req_valid` and `req_ready` are both high. `rsp_valid` is high in exactly the cycle after an accepted read, and `rsp_data` is zero whenever `rsp_valid` is low.
- R2: `req_addr[PIX_IDX_W+1:PIX_IDX_W]` selects the window: 0 is the full view, 1 is the colour view, 2 is the byte view and 3 is reserved. `req_addr[PIX_IDX_W-1:0]` is the pixel index in the full and colour views and the word index in the byte view.
- R3: A full-view write stores red from `req_wdata[7:0]`, green from `[15:8]`, blue from `[23:16]` and mode from `[25:24]`. Data bits 31:26 and `req_be` are ignored.
- R4: A full-view read returns the pixel's mode in bits 25:24, blue, green and red in bits 23:0, and zero in bits 31:26.
- R5: A colour-view write updates red, green and blue from data bits 7:0, 15:8 and 23:16. The stored mode bits are left unchanged and data bits 31:24 are ignored.
- R6: A colour-view read returns the 24 colour bits with bits 31:24 zero.
- R7: Byte-view word w covers pixels 4w to 4w+3, with pixel 4w+k in data byte k (bits 8k+7:8k). A write stores the red plane of pixel 4w+k only where `req_be[k]` is set. Green, blue and mode, and lanes whose strobe is clear, keep their values.
- R8: A byte-view read of word w returns the red planes of pixels 4w+3 to 4w, packed in byte lanes 3 to 0.
- R9: Byte-view word indices of 2^PIX_IDX_W/4 and above read as zero, and writes to them change no pixel.
- R10: The reserved window reads as zero, and writes to it change no pixel.
- R11: A read in the cycle right after a write to the same pixel returns the newly written value in every combination of windows.
- R12: While `rst_n` is low, `req_ready` and `rsp_valid` are low and `rsp_data` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | PIX_IDX_W+2 | Window select (top two bits) and pixel or word index |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte-lane strobes, used by the byte view only |
| rsp_valid | output | 1 | Read data valid |
| rsp_data | output | 32 | Formatted read data, zero when not valid |

## Verification
A write changes the store at the clock edge that accepts it. Read data appears on `rsp_data` with `rsp_valid` exactly one edge after the request is accepted. The bench therefore drives every request on a falling edge and, on the next falling edge, compares the response port with an expectation computed from its own pixel array when the request was issued, so every clock is checked and the response is sampled in the single cycle it is due. Effects that writes must not have, on the mode bits, on other planes, on lanes with clear strobes, and through out-of-range or reserved windows, are made visible by full-view reads that follow at once and are compared in the same way.

// File: rtl/pix_ap_pkg.sv
// Shared types for the multi-view pixel aperture.
// Assumes four byte lanes per host word, so four pixel banks.
package pix_ap_pkg;

    localparam int LANES = 4;

    // Window codes carried in the top two address bits.
    typedef enum logic [1:0] {
        WIN_FULL  = 2'd0,
        WIN_COLOR = 2'd1,
        WIN_RED8  = 2'd2,
        WIN_NONE  = 2'd3
    } win_e;

    // One stored pixel; packed so that bits 25:0 equal the full-view word.
    typedef struct packed {
        logic [1:0] mode;
        logic [7:0] blu;
        logic [7:0] grn;
        logic [7:0] red;
    } pix_t;

    // Per-field write enables for one bank.
    typedef struct packed {
        logic mode;
        logic blu;
        logic grn;
        logic red;
    } fld_we_t;

endpackage

// File: rtl/pix_bank.sv
// One pixel bank: a synchronous RAM of pix_t rows with a write enable per field.
// Assumes at most one access per cycle. Storage is not reset; the read register is.
module pix_bank
    import pix_ap_pkg::*;
#(
    parameter int ROW_W = 4,
    localparam int ROWS = 1 << ROW_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  fld_we_t          we,
    input  logic [ROW_W-1:0] row,
    input  pix_t             wpix,
    input  logic             rd_en,
    output pix_t             rpix
);

    pix_t mem [ROWS];

    // Field-masked write: each plane and the mode bits update on their own enable.
    always_ff @(posedge clk) begin
        if (we.red)  mem[row].red  <= wpix.red;
        if (we.grn)  mem[row].grn  <= wpix.grn;
        if (we.blu)  mem[row].blu  <= wpix.blu;
        if (we.mode) mem[row].mode <= wpix.mode;
    end

    // Registered read of the whole row when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)     rpix <= '0;
        else if (rd_en) rpix <= mem[row];
    end

endmodule

// File: rtl/pix_win_decode.sv
// Window decoder: turns an accepted request into a bank row, per-bank read
// enables, per-bank per-field write enables and per-bank write data.
// Also exports the read context (window, lane, range) for the response path.
// Assumes PIX_IDX_W >= 3 so that each bank holds at least two rows.
module pix_win_decode
    import pix_ap_pkg::*;
#(
    parameter int PIX_IDX_W = 6,
    localparam int ROW_W  = PIX_IDX_W - 2,
    localparam int ADDR_W = PIX_IDX_W + 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc,
    input  logic                   write,
    input  logic [ADDR_W-1:0]      addr,
    input  logic [31:0]            wdata,
    input  logic [3:0]             be,
    output logic [ROW_W-1:0]       row,
    output logic [LANES-1:0]       rd_en,
    output fld_we_t [LANES-1:0]    we,
    output pix_t [LANES-1:0]       wpix,
    output win_e                   win,
    output logic [1:0]             lane,
    output logic                   in_range
);

    logic [PIX_IDX_W-1:0] idx;
    logic [LANES-1:0]     we_any;
    logic [5:0]           unused_hi;

    assign win       = win_e'(addr[ADDR_W-1 -: 2]);
    assign idx       = addr[PIX_IDX_W-1:0];
    assign lane      = idx[1:0];
    assign in_range  = (idx[PIX_IDX_W-1 -: 2] == 2'b00);
    assign unused_hi = wdata[31:26];

    // Row select: byte view uses the low word-index bits, pixel views drop the lane bits.
    always_comb begin
        if (win == WIN_RED8) row = idx[ROW_W-1:0];
        else                 row = idx[PIX_IDX_W-1:2];
    end

    // Per-bank enables and data for the selected window.
    always_comb begin
        for (int b = 0; b < LANES; b++) begin
            we[b]        = '0;
            rd_en[b]     = 1'b0;
            wpix[b].mode = wdata[25:24];
            wpix[b].blu  = wdata[23:16];
            wpix[b].grn  = wdata[15:8];
            wpix[b].red  = (win == WIN_RED8) ? wdata[8*b +: 8] : wdata[7:0];
            if (acc) begin
                unique case (win)
                    WIN_FULL: begin
                        if (lane == 2'(b)) begin
                            we[b]    = write ? 4'b1111 : 4'b0000;
                            rd_en[b] = !write;
                        end
                    end
                    WIN_COLOR: begin
                        if (lane == 2'(b)) begin
                            we[b]    = write ? 4'b0111 : 4'b0000;
                            rd_en[b] = !write;
                        end
                    end
                    WIN_RED8: begin
                        if (in_range) begin
                            we[b].red = write && be[b];
                            rd_en[b]  = !write;
                        end
                    end
                    default: ;
                endcase
            end
            we_any[b] = |we[b];
        end
    end

    AST_NONE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && win == WIN_NONE) |-> (we_any == '0 && rd_en == '0)); // R10

    AST_COLOR_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && win == WIN_COLOR) |-> !(we[0].mode || we[1].mode || we[2].mode || we[3].mode)); // R5

    AST_RED8_RED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && win == WIN_RED8) |-> !(we[0].grn || we[1].grn || we[2].grn || we[3].grn ||
                                       we[0].blu || we[1].blu || we[2].blu || we[3].blu ||
                                       we[0].mode || we[1].mode || we[2].mode || we[3].mode)); // R7

    AST_RED8_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && win == WIN_RED8 && !in_range) |-> (we_any == '0 && rd_en == '0)); // R9

    AST_ONE_PIXEL: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && (win == WIN_FULL || win == WIN_COLOR)) |-> ($onehot0(we_any) && $onehot0(rd_en))); // R3

endmodule

// File: rtl/pix_rd_fmt.sv
// Read formatter: shapes the registered bank outputs into the host word of the
// window that issued the read. Purely combinational; drives zero when idle.
// Assumes the context inputs are the registered copies of the request's decode.
module pix_rd_fmt
    import pix_ap_pkg::*;
(
    input  logic               valid,
    input  win_e               win,
    input  logic [1:0]         lane,
    input  logic               in_range,
    input  pix_t [LANES-1:0]   rpix,
    output logic [31:0]        data
);

    pix_t        sel;
    logic [31:0] reds;

    // Pick the bank of a single-pixel read and gather the red planes of all lanes.
    always_comb begin
        sel = rpix[lane];
        for (int b = 0; b < LANES; b++) reds[8*b +: 8] = rpix[b].red;
    end

    // Apply the window's zero-fill.
    always_comb begin
        data = '0;
        if (valid) begin
            unique case (win)
                WIN_FULL:  data = {6'b0, sel};
                WIN_COLOR: data = {8'b0, sel.blu, sel.grn, sel.red};
                WIN_RED8:  data = in_range ? reds : 32'b0;
                default:   data = '0;
            endcase
        end
    end

endmodule

// File: rtl/pix_aperture.sv
// Multi-view pixel aperture top: a valid/ready host port over a four-bank
// 26-bit pixel store, seen through a full, a colour-only and a red-byte window.
// Assumes one request per cycle; read data is due one cycle after acceptance.
module pix_aperture
    import pix_ap_pkg::*;
#(
    parameter int PIX_IDX_W = 6,
    localparam int ROW_W  = PIX_IDX_W - 2,
    localparam int ADDR_W = PIX_IDX_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [3:0]        req_be,
    output logic              rsp_valid,
    output logic [31:0]       rsp_data
);

    logic               ready_q;
    logic               acc;
    logic               rd_acc;
    logic [ROW_W-1:0]   row;
    logic [LANES-1:0]   bank_rd;
    fld_we_t [LANES-1:0] bank_we;
    pix_t [LANES-1:0]   bank_wpix;
    pix_t [LANES-1:0]   bank_rpix;
    win_e               dec_win;
    logic [1:0]         dec_lane;
    logic               dec_inr;
    logic               rsp_v_q;
    win_e               win_q;
    logic [1:0]         lane_q;
    logic               inr_q;

    assign acc       = req_valid && ready_q;
    assign rd_acc    = acc && !req_write;
    assign req_ready = ready_q;
    assign rsp_valid = rsp_v_q;

    // Ready rises on the first edge after reset and then stays high.
    always_ff @(posedge clk) begin
        if (!rst_n) ready_q <= 1'b0;
        else        ready_q <= 1'b1;
    end

    // Hold the read context for the response cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_v_q <= 1'b0;
            win_q   <= WIN_NONE;
            lane_q  <= 2'b00;
            inr_q   <= 1'b0;
        end else begin
            rsp_v_q <= rd_acc;
            if (rd_acc) begin
                win_q  <= dec_win;
                lane_q <= dec_lane;
                inr_q  <= dec_inr;
            end
        end
    end

    pix_win_decode #(.PIX_IDX_W(PIX_IDX_W)) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .write    (req_write),
        .addr     (req_addr),
        .wdata    (req_wdata),
        .be       (req_be),
        .row      (row),
        .rd_en    (bank_rd),
        .we       (bank_we),
        .wpix     (bank_wpix),
        .win      (dec_win),
        .lane     (dec_lane),
        .in_range (dec_inr)
    );

    for (genvar b = 0; b < LANES; b++) begin : g_bank
        pix_bank #(.ROW_W(ROW_W)) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (bank_we[b]),
            .row   (row),
            .wpix  (bank_wpix[b]),
            .rd_en (bank_rd[b]),
            .rpix  (bank_rpix[b])
        );
    end

    pix_rd_fmt u_fmt (
        .valid    (rsp_v_q),
        .win      (win_q),
        .lane     (lane_q),
        .in_range (inr_q),
        .rpix     (bank_rpix),
        .data     (rsp_data)
    );

    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_acc |=> rsp_valid); // R1

    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_acc |=> !rsp_valid); // R1

    AST_IDLE_DATA_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (rsp_data == 32'b0)); // R1

    AST_FULL_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && dec_win == WIN_FULL) |=> (rsp_data[31:26] == 6'b0)); // R4

    AST_COLOR_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && dec_win == WIN_COLOR) |=> (rsp_data[31:24] == 8'b0)); // R6

    AST_NONE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && dec_win == WIN_NONE) |=> (rsp_data == 32'b0)); // R10

    AST_RANGE_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_acc && dec_win == WIN_RED8 && !dec_inr) |=> (rsp_data == 32'b0)); // R9

endmodule

// File: tb/tb_pix_aperture.sv
// Bench: a behavioural pixel array predicts every response; outputs are
// compared on each falling edge against the expectation of the previous request.
module tb_pix_aperture;

    localparam int PIX_IDX_W = 6;
    localparam int PIXELS    = 1 << PIX_IDX_W;
    localparam int ADDR_W    = PIX_IDX_W + 2;
    localparam bit [1:0] W_FULL = 2'd0, W_COL = 2'd1, W_BYTE = 2'd2, W_RES = 2'd3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic              req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [31:0]       req_wdata = '0;
    logic [3:0]        req_be = '0;
    logic              rsp_valid;
    logic [31:0]       rsp_data;

    int checks = 0;
    int errors = 0;

    logic [25:0] model [PIXELS];
    bit          exp_v = 1'b0;
    bit [31:0]   exp_d = '0;
    string       exp_tag = "R1";

    always #5 clk = ~clk;

    pix_aperture #(.PIX_IDX_W(PIX_IDX_W)) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rsp_valid(rsp_valid), .rsp_data(rsp_data)
    );

    function automatic bit [31:0] model_read(bit [1:0] w, int idx);
        bit [31:0] r = '0;
        case (w)
            W_FULL: r = {6'b0, model[idx]};
            W_COL:  r = {8'b0, model[idx][23:0]};
            W_BYTE: if (idx < PIXELS / 4)
                        for (int k = 0; k < 4; k++) r[8*k +: 8] = model[4*idx + k][7:0];
            default: r = '0;
        endcase
        return r;
    endfunction

    function automatic void model_write(bit [1:0] w, int idx, bit [31:0] wd, bit [3:0] be);
        case (w)
            W_FULL: model[idx] = wd[25:0];
            W_COL:  model[idx][23:0] = wd[23:0];
            W_BYTE: if (idx < PIXELS / 4)
                        for (int k = 0; k < 4; k++)
                            if (be[k]) model[4*idx + k][7:0] = wd[8*k +: 8];
            default: ;
        endcase
    endfunction

    // Compare the ports with the expectation left by the previous request.
    task automatic check_prev();
        checks++;
        if (req_ready !== 1'b1 || rsp_valid !== exp_v || rsp_data !== exp_d) begin
            errors++;
            $display("FAIL %s: ready=%0b valid=%0b data=%h expected ready=1 valid=%0b data=%h",
                     exp_tag, req_ready, rsp_valid, rsp_data, exp_v, exp_d);
        end
    endtask

    task automatic step(input bit v, input bit wr, input bit [1:0] w, input int idx,
                        input bit [31:0] wd, input bit [3:0] be, input string tag);
        @(negedge clk);
        check_prev();
        req_valid = v;
        req_write = wr;
        req_addr  = {w, PIX_IDX_W'(idx)};
        req_wdata = wd;
        req_be    = be;
        exp_v     = v && !wr;
        exp_d     = exp_v ? model_read(w, idx) : 32'b0;
        exp_tag   = tag;
        if (v && wr) model_write(w, idx, wd, be);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        // R12: outputs quiet while reset is held
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (req_ready !== 1'b0 || rsp_valid !== 1'b0 || rsp_data !== 32'b0) begin
            errors++;
            $display("FAIL R12: ready=%0b valid=%0b data=%h expected ready=0 valid=0 data=0",
                     req_ready, rsp_valid, rsp_data);
        end
        rst_n = 1'b1;
        exp_v = 1'b0;
        exp_d = '0;
        exp_tag = "R1";

        // Fill the store through the full view (R3)
        for (int i = 0; i < PIXELS; i++) step(1, 1, W_FULL, i, $urandom, 4'h0, "R3");
        for (int i = 0; i < PIXELS; i++) step(1, 0, W_FULL, i, 0, 4'h0, "R4");

        // R3/R4: high data bits and strobes ignored on full writes
        step(1, 1, W_FULL, 7, 32'hFFAB_CDEF, 4'h0, "R3");
        step(1, 0, W_FULL, 7, 0, 4'h0, "R4");
        step(0, 0, W_FULL, 0, 0, 4'h0, "R1");

        // R5/R6: colour writes keep mode; colour reads zero the high byte
        step(1, 1, W_FULL, 5, 32'h0312_3456, 4'h0, "R3");
        step(1, 1, W_COL, 5, 32'hFF65_4321, 4'hF, "R5");
        step(1, 0, W_FULL, 5, 0, 4'h0, "R5");
        step(1, 0, W_COL, 5, 0, 4'h0, "R6");

        // R7/R8: partial strobes on byte word 2 (pixels 8..11)
        step(1, 1, W_BYTE, 2, 32'hA1B2_C3D4, 4'b0101, "R7");
        for (int i = 8; i < 12; i++) step(1, 0, W_FULL, i, 0, 4'h0, "R7");
        step(1, 0, W_BYTE, 2, 0, 4'h0, "R8");
        step(1, 1, W_BYTE, 15, 32'h1122_3344, 4'hF, "R7");
        step(1, 0, W_BYTE, 15, 0, 4'h0, "R8");

        // R9: out-of-range byte words read zero and touch nothing
        step(1, 1, W_BYTE, 20, 32'hDEAD_BEEF, 4'hF, "R9");
        step(1, 0, W_BYTE, 20, 0, 4'h0, "R9");
        for (int i = 16; i < 20; i++) step(1, 0, W_FULL, i, 0, 4'h0, "R9");

        // R10: reserved window
        step(1, 1, W_RES, 3, 32'h0000_0000, 4'hF, "R10");
        step(1, 0, W_RES, 3, 0, 4'h0, "R10");
        step(1, 0, W_FULL, 3, 0, 4'h0, "R10");

        // R11: back-to-back write then read of the same pixel
        step(1, 1, W_FULL, 30, 32'h0255_AA11, 4'h0, "R11");
        step(1, 0, W_FULL, 30, 0, 4'h0, "R11");
        step(1, 1, W_BYTE, 7, 32'h7766_5544, 4'b1000, "R11");
        step(1, 0, W_FULL, 31, 0, 4'h0, "R11");
        step(1, 1, W_COL, 31, 32'h0099_8877, 4'h0, "R11");
        step(1, 0, W_BYTE, 7, 0, 4'h0, "R11");

        // R2: mixed random traffic over every window
        for (int n = 0; n < 4000; n++)
            step(($urandom % 5) != 0, $urandom % 2, 2'($urandom % 4), $urandom % PIXELS,
                 $urandom, 4'($urandom), "R2");

        step(0, 0, W_FULL, 0, 0, 4'h0, "R1");
        @(negedge clk);
        check_prev();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule